// File: doc/BRIEF.md
# Interruption State Capture Bank

This block keeps the processor status word and a bank of twelve control registers that record machine state when an interruption is taken. The bank sits at control-register indices 16 to 27. Index 16 holds a copy of the status word taken at the interruption, and a return-from-interruption puts that copy back. Index 17 holds the cause word, which records the kind of access that faulted, a vector number and a code. Indices 18 to 27 are plain storage that handlers save and restore.

One status bit, the collection enable, controls the bank. While it is 1, an event captures the status word and the bank is closed to software: any read or write to an index in the bank raises an illegal-operation fault pulse instead of completing. The cause word follows its own rule. Every event writes it, whatever the enable bit is, except a nested data-translation fault. A valid flag tells whether the bank contents are defined. An interruption that clears the enable bit sets the flag. A direct software write of the status word clears it.

Top module: `intr_state_bank`

## Requirements
- R1: Synchronous active-high reset clears the status word, the saved status, the cause word, all ten storage registers and the valid flag. `rsp_valid` and `fault` are low after reset.
- R2: A read or write at index 16 to 27 while status bit 13 (collection enable) is 1 pulses `fault` on the next cycle. `rsp_valid` stays low and the target register keeps its value.
- R3: An event while bit 13 is 1 has three effects at the next edge. The saved status takes the full status word. Bit 13 of the status word clears and every other status bit is kept. `bank_valid` sets.
- R4: An event while bit 13 is 0 leaves the saved status, the status word and `bank_valid` unchanged.
- R5: Every event writes the cause word unless `ev_nested_dtlb` is 1. A nested event leaves the cause word unchanged.
- R6: The cause word layout is: code at bits [15:0], vector at [23:16], and `ev_flags[i]` at bit 32+i. The flags, in order from i=0 to i=8, are execute, write, read, non-access, speculative, register-stack, incomplete-register-frame, nested, and single-step-outstanding. `ev_ei` goes to [42:41] and `ev_ed` to bit 43. Several flags may be set at once; a faulting semaphore access sets both read and write.
- R7: Cause bits [31:24] and [63:44] always read as zero, including after a software write of all ones to index 17.
- R8: A `rfi` pulse with no event in the same cycle loads the status word from the saved status at the next edge.
- R9: A `status_wr_en` pulse with no event and no `rfi` in the same cycle loads the status word from `status_wr_data` and clears `bank_valid`.
- R10: While bit 13 is 0, an access at index 16 to 27 completes. `rsp_valid` is 1 on the next cycle. A read returns the register in `rsp_rdata`, and a write updates the register (index 17 only in its writable bits). An access at any other index gives neither `rsp_valid` nor `fault`.
- R11: In the same cycle an event takes precedence over `rfi`, over `status_wr_en`, and over a software write to index 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_wr_en | input | 1 | Direct software write of the status word |
| status_wr_data | input | 64 | Value for a direct status write |
| status_word | output | 64 | Live status word; bit 13 is collection enable |
| ev_valid | input | 1 | Interruption event strobe |
| ev_flags | input | 9 | Access-kind flags of the event (order in R6) |
| ev_ei | input | 2 | Slot index of the excepting instruction |
| ev_ed | input | 1 | Exception-deferral attribute |
| ev_vector | input | 8 | Event vector number |
| ev_code | input | 16 | Event-specific code |
| ev_nested_dtlb | input | 1 | Event is a nested data-translation fault |
| rfi | input | 1 | Return-from-interruption strobe |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 7 | Control-register index |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Access completed (one cycle after request) |
| rsp_rdata | output | 64 | Read data, valid with rsp_valid on a read |
| fault | output | 1 | Illegal-operation fault pulse |
| saved_status | output | 64 | Saved status word used for restore |
| bank_valid | output | 1 | Bank contents were defined by an interruption |

The access port has a valid strobe and no ready signal. It never applies back-pressure: the block accepts every request in the cycle it is presented, and the response cannot be stalled.

## Verification
Every result is registered once. Status word, saved status, cause word, `bank_valid`, `rsp_valid`, `rsp_rdata` and `fault` all reflect a stimulus one clock edge after the cycle in which it was presented. Each bench task therefore drives its inputs 1 ns after a rising edge, waits for exactly one further rising edge, and samples 1 ns later, after removing the stimulus. State that an access must leave unchanged is read back in later access cycles, after bit 13 has been cleared.

// File: rtl/icap_pkg.sv
`timescale 1ns/1ps
package icap_pkg;
  localparam int DATA_W   = 64;
  localparam int FLAG_N   = 9;
  localparam int CODE_W   = 16;
  localparam int VEC_W    = 8;
  localparam int EI_W     = 2;

  // bits software may set in the cause word: code, vector, flags, ei, ed
  function automatic logic [DATA_W-1:0] cause_wr_mask();
    return {20'h0, 12'hFFF, 8'h00, 24'hFF_FFFF};
  endfunction

  function automatic logic [DATA_W-1:0] pack_cause(
      input logic [FLAG_N-1:0] flags,
      input logic [EI_W-1:0]   ei,
      input logic              ed,
      input logic [VEC_W-1:0]  vec,
      input logic [CODE_W-1:0] code);
    return {20'h0, ed, ei, flags, 8'h00, vec, code};
  endfunction
endpackage

// File: rtl/icap_access_decode.sv
`timescale 1ns/1ps
module icap_access_decode #(
  parameter int IDX_W = 7,
  parameter int BASE  = 16,
  parameter int NREG  = 12,
  localparam int OFF_W = $clog2(NREG)
) (
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             ce,
  output logic             hit_ok,
  output logic             hit_deny,
  output logic [OFF_W-1:0] offset
);
  logic [IDX_W-1:0] diff;
  logic             in_bank;

  always_comb begin
    diff     = acc_idx - IDX_W'(BASE);
    in_bank  = (acc_idx >= IDX_W'(BASE)) && (diff < IDX_W'(NREG));
    offset   = diff[OFF_W-1:0];
    hit_ok   = acc_valid && in_bank && !ce;
    hit_deny = acc_valid && in_bank && ce;
  end
endmodule

// File: rtl/icap_status_ctl.sv
`timescale 1ns/1ps
module icap_status_ctl #(
  parameter int DATA_W = 64,
  parameter int CE_BIT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              rfi,
  input  logic              st_we,
  input  logic [DATA_W-1:0] st_wdata,
  input  logic              sv_we,
  input  logic [DATA_W-1:0] sv_wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] saved_q,
  output logic              valid_q,
  output logic              ce
);
  localparam logic [DATA_W-1:0] CE_MASK = DATA_W'(1) << CE_BIT;

  assign ce = status_q[CE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      saved_q  <= '0;
      valid_q  <= 1'b0;
    end else if (ev_valid && ce) begin
      saved_q  <= status_q;
      status_q <= status_q & ~CE_MASK;
      valid_q  <= 1'b1;
    end else begin
      if (sv_we) saved_q <= sv_wdata;
      if (!ev_valid) begin
        if (rfi) begin
          status_q <= saved_q;
        end else if (st_we) begin
          status_q <= st_wdata;
          valid_q  <= 1'b0;
        end
      end
    end
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ce |=> saved_q == $past(status_q) && !ce && valid_q);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ce && !sv_we |=> $stable(saved_q) && $stable(valid_q) && $stable(status_q));
  a_r8_restore: assert property (@(posedge clk) disable iff (rst)
    rfi && !ev_valid |=> status_q == $past(saved_q));
  a_r9_swclear: assert property (@(posedge clk) disable iff (rst)
    st_we && !rfi && !ev_valid |=> !valid_q);
endmodule

// File: rtl/icap_cause_reg.sv
`timescale 1ns/1ps
module icap_cause_reg
  import icap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_nested,
  input  logic [DATA_W-1:0] ev_word,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] cause_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
    end else if (ev_valid) begin
      if (!ev_nested) cause_q <= ev_word & cause_wr_mask();
    end else if (sw_we) begin
      cause_q <= sw_wdata & cause_wr_mask();
    end
  end

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    sw_we && !ev_valid |=> cause_q[31:24] == 8'h0 && cause_q[63:44] == 20'h0);
  a_r5_nested_keeps: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_nested |=> $stable(cause_q));
endmodule

// File: rtl/intr_state_bank.sv
`timescale 1ns/1ps
module intr_state_bank
  import icap_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int BASE   = 16,
  parameter int NREG   = 12,
  parameter int CE_BIT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              status_wr_en,
  input  logic [63:0]       status_wr_data,
  output logic [63:0]       status_word,
  input  logic              ev_valid,
  input  logic [8:0]        ev_flags,
  input  logic [1:0]        ev_ei,
  input  logic              ev_ed,
  input  logic [7:0]        ev_vector,
  input  logic [15:0]       ev_code,
  input  logic              ev_nested_dtlb,
  input  logic              rfi,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [63:0]       acc_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              fault,
  output logic [63:0]       saved_status,
  output logic              bank_valid
);
  localparam int OFF_W = $clog2(NREG);
  localparam int GEN_N = NREG - 2;   // plain storage after saved status and cause

  logic             hit_ok, hit_deny, ce;
  logic [OFF_W-1:0] offset;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] bank_rd [NREG];
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ok;

  assign wr_ok = hit_ok && acc_write;

  icap_access_decode #(.IDX_W(IDX_W), .BASE(BASE), .NREG(NREG)) u_dec (
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx),
    .ce        (ce),
    .hit_ok    (hit_ok),
    .hit_deny  (hit_deny),
    .offset    (offset)
  );

  icap_status_ctl #(.DATA_W(DATA_W), .CE_BIT(CE_BIT)) u_st (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .rfi      (rfi),
    .st_we    (status_wr_en),
    .st_wdata (status_wr_data),
    .sv_we    (wr_ok && offset == OFF_W'(0)),
    .sv_wdata (acc_wdata),
    .status_q (status_word),
    .saved_q  (saved_status),
    .valid_q  (bank_valid),
    .ce       (ce)
  );

  icap_cause_reg u_cause (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (ev_valid),
    .ev_nested (ev_nested_dtlb),
    .ev_word   (pack_cause(ev_flags, ev_ei, ev_ed, ev_vector, ev_code)),
    .sw_we     (wr_ok && offset == OFF_W'(1)),
    .sw_wdata  (acc_wdata),
    .cause_q   (cause_q)
  );

  assign bank_rd[0] = saved_status;
  assign bank_rd[1] = cause_q;

  for (genvar g = 0; g < GEN_N; g++) begin : g_store
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_ok && offset == OFF_W'(g + 2)) q <= acc_wdata;
    end
    assign bank_rd[g + 2] = q;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (offset == OFF_W'(i)) rd_mux = bank_rd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      fault     <= 1'b0;
    end else begin
      rsp_valid <= hit_ok;
      fault     <= hit_deny;
      if (hit_ok && !acc_write) rsp_rdata <= rd_mux;
    end
  end

  a_r2_fault_blocks: assert property (@(posedge clk) disable iff (rst)
    hit_deny |=> fault && !rsp_valid);
  a_r10_outside_silent: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !hit_ok && !hit_deny |=> !rsp_valid && !fault);
  a_r6_layout: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ev_nested_dtlb |=> cause_q[15:0] == $past(ev_code)
      && cause_q[23:16] == $past(ev_vector) && cause_q[40:32] == $past(ev_flags));
  a_r11_event_first: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ce && (rfi || status_wr_en) |=> !ce && bank_valid);
endmodule

// File: tb/intr_state_bank_test.sv
`timescale 1ns/1ps
module intr_state_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        status_wr_en = 1'b0;
  logic [63:0] status_wr_data = '0;
  logic [63:0] status_word;
  logic        ev_valid = 1'b0;
  logic [8:0]  ev_flags = '0;
  logic [1:0]  ev_ei = '0;
  logic        ev_ed = 1'b0;
  logic [7:0]  ev_vector = '0;
  logic [15:0] ev_code = '0;
  logic        ev_nested_dtlb = 1'b0;
  logic        rfi = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [6:0]  acc_idx = '0;
  logic [63:0] acc_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        fault;
  logic [63:0] saved_status;
  logic        bank_valid;

  int checks = 0;
  int errors = 0;
  localparam logic [63:0] CE = 64'h2000;

  always #2.5 clk = ~clk;

  intr_state_bank uut (.*);

  function automatic logic [63:0] exp_cause(input logic [8:0] f, input logic [1:0] ei,
      input logic ed, input logic [7:0] v, input logic [15:0] c);
    logic [63:0] w;
    w = '0;
    w[15:0] = c; w[23:16] = v; w[40:32] = f; w[42:41] = ei; w[43] = ed;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic access(input bit wr, input logic [6:0] idx, input logic [63:0] d,
                        output bit rv, output bit f, output logic [63:0] rd);
    acc_valid = 1'b1; acc_write = wr; acc_idx = idx; acc_wdata = d;
    step();
    acc_valid = 1'b0; acc_write = 1'b0;
    rv = rsp_valid; f = fault; rd = rsp_rdata;
  endtask

  task automatic set_status(input logic [63:0] v);
    status_wr_en = 1'b1; status_wr_data = v;
    step();
    status_wr_en = 1'b0;
  endtask

  task automatic fire(input logic [8:0] f, input logic [1:0] ei, input logic ed,
                      input logic [7:0] v, input logic [15:0] c, input bit nested);
    ev_valid = 1'b1; ev_flags = f; ev_ei = ei; ev_ed = ed; ev_vector = v; ev_code = c;
    ev_nested_dtlb = nested;
    step();
    ev_valid = 1'b0; ev_nested_dtlb = 1'b0;
  endtask

  task automatic t_reset();
    bit rv, f; logic [63:0] rd;
    chk(status_word == 0, "R1 status", status_word, 0);
    chk(!bank_valid && !rsp_valid && !fault, "R1 flags", {bank_valid, rsp_valid, fault}, 0);
    access(0, 7'd17, 0, rv, f, rd);
    chk(rv && rd == 0, "R1 cause", rd, 0);
    access(0, 7'd25, 0, rv, f, rd);
    chk(rv && rd == 0, "R1 storage", rd, 0);
  endtask

  task automatic t_access();
    bit rv, f; logic [63:0] rd;
    access(1, 7'd20, 64'h1111_2222_3333_4444, rv, f, rd);
    chk(rv && !f, "R10 write ack", {rv, f}, 2'b10);
    access(1, 7'd27, 64'hDEAD_BEEF_0000_0001, rv, f, rd);
    access(0, 7'd20, 0, rv, f, rd);
    chk(rv && rd == 64'h1111_2222_3333_4444, "R10 read 20", rd, 64'h1111_2222_3333_4444);
    access(0, 7'd27, 0, rv, f, rd);
    chk(rd == 64'hDEAD_BEEF_0000_0001, "R10 read 27", rd, 64'hDEAD_BEEF_0000_0001);
    access(0, 7'd15, 0, rv, f, rd);
    chk(!rv && !f, "R10 index 15 unclaimed", {rv, f}, 0);
    access(1, 7'd28, 64'h5, rv, f, rd);
    chk(!rv && !f, "R10 index 28 unclaimed", {rv, f}, 0);
  endtask

  task automatic t_event_on();
    bit rv, f; logic [63:0] rd;
    set_status(64'hA5A5_0000_1234_2000);
    fire(9'b0_0000_0110, 2'd2, 1'b1, 8'h2C, 16'h0055, 0);
    chk(status_word == 64'hA5A5_0000_1234_0000, "R3 enable cleared", status_word, 64'hA5A5_0000_1234_0000);
    chk(saved_status == 64'hA5A5_0000_1234_2000, "R3 saved", saved_status, 64'hA5A5_0000_1234_2000);
    chk(bank_valid, "R3 valid", bank_valid, 1);
    access(0, 7'd17, 0, rv, f, rd);
    chk(rd == exp_cause(9'h006, 2'd2, 1, 8'h2C, 16'h0055), "R6 semaphore cause", rd,
        exp_cause(9'h006, 2'd2, 1, 8'h2C, 16'h0055));
    access(0, 7'd16, 0, rv, f, rd);
    chk(rv && rd == 64'hA5A5_0000_1234_2000, "R10 read saved", rd, 64'hA5A5_0000_1234_2000);
  endtask

  task automatic t_fault();
    bit rv, f; logic [63:0] rd;
    set_status(64'h0000_0000_0000_2001);
    chk(!bank_valid, "R9 valid cleared", bank_valid, 0);
    chk(status_word == 64'h2001, "R9 status written", status_word, 64'h2001);
    access(1, 7'd20, 64'hFFFF_FFFF_FFFF_FFFF, rv, f, rd);
    chk(f && !rv, "R2 write faults", {f, rv}, 2'b10);
    access(0, 7'd17, 0, rv, f, rd);
    chk(f && !rv, "R2 read faults", {f, rv}, 2'b10);
    step();
    chk(!fault, "R2 single pulse", fault, 0);
    set_status(64'h0000_0000_0000_0001);
    access(0, 7'd20, 0, rv, f, rd);
    chk(rd == 64'h1111_2222_3333_4444, "R2 target kept", rd, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_event_off();
    bit rv, f; logic [63:0] rd;
    fire(9'b0_0001_0100, 2'd1, 0, 8'h1F, 16'hBEEF, 0);
    chk(saved_status == 64'hA5A5_0000_1234_2000, "R4 saved kept", saved_status, 64'hA5A5_0000_1234_2000);
    chk(!bank_valid && status_word == 64'h1, "R4 valid/status kept", status_word, 64'h1);
    access(0, 7'd17, 0, rv, f, rd);
    chk(rd == exp_cause(9'h014, 2'd1, 0, 8'h1F, 16'hBEEF), "R5 cause on enable=0", rd,
        exp_cause(9'h014, 2'd1, 0, 8'h1F, 16'hBEEF));
  endtask

  task automatic t_nested();
    bit rv, f; logic [63:0] rd;
    fire(9'h1FF, 2'd3, 1, 8'hFF, 16'hFFFF, 1);
    access(0, 7'd17, 0, rv, f, rd);
    chk(rd == exp_cause(9'h014, 2'd1, 0, 8'h1F, 16'hBEEF), "R5 nested keeps cause", rd,
        exp_cause(9'h014, 2'd1, 0, 8'h1F, 16'hBEEF));
  endtask

  task automatic t_reserved();
    bit rv, f; logic [63:0] rd;
    access(1, 7'd17, 64'hFFFF_FFFF_FFFF_FFFF, rv, f, rd);
    access(0, 7'd17, 0, rv, f, rd);
    chk(rd == 64'h0000_0FFF_00FF_FFFF, "R7 reserved zero", rd, 64'h0000_0FFF_00FF_FFFF);
  endtask

  task automatic t_rfi();
    bit rv, f; logic [63:0] rd;
    access(1, 7'd16, 64'h0123_4567_89AB_2DEF, rv, f, rd);
    rfi = 1'b1; step(); rfi = 1'b0;
    chk(status_word == 64'h0123_4567_89AB_2DEF, "R8 restore", status_word, 64'h0123_4567_89AB_2DEF);
  endtask

  task automatic t_priority();
    bit rv, f; logic [63:0] rd;
    set_status(64'h0000_00F0_0000_2002);
    ev_valid = 1'b1; rfi = 1'b1; status_wr_en = 1'b1; status_wr_data = 64'h7777;
    ev_flags = 9'h001; ev_ei = 0; ev_ed = 0; ev_vector = 8'h08; ev_code = 16'h0001;
    acc_valid = 1'b0;
    step();
    ev_valid = 1'b0; rfi = 1'b0; status_wr_en = 1'b0;
    chk(status_word == 64'h0000_00F0_0000_0002, "R11 event over rfi/write", status_word,
        64'h0000_00F0_0000_0002);
    chk(saved_status == 64'h0000_00F0_0000_2002 && bank_valid, "R11 saved", saved_status,
        64'h0000_00F0_0000_2002);
    // event and software cause write in one cycle, enable now 0
    ev_valid = 1'b1; ev_flags = 9'h100; ev_vector = 8'h44; ev_code = 16'h0A0A;
    acc_valid = 1'b1; acc_write = 1'b1; acc_idx = 7'd17; acc_wdata = 64'h0000_0000_0012_3456;
    step();
    ev_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    access(0, 7'd17, 0, rv, f, rd);
    chk(rd == exp_cause(9'h100, 0, 0, 8'h44, 16'h0A0A), "R11 event over cause write", rd,
        exp_cause(9'h100, 0, 0, 8'h44, 16'h0A0A));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    step();
    t_reset();
    t_access();
    t_event_on();
    t_fault();
    t_event_off();
    t_nested();
    t_reserved();
    t_rfi();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule